// File: doc/BRIEF.md
# DDR SDRAM Command Bus Protocol Monitor

This block watches the command bus of one DDR SDRAM rank without driving anything. On each rising clock edge it samples chip select, the three strobes (row, column, write enable), the two bank-select bits and address bit 10. It decodes the command and keeps an idle/open model of four banks. Any command that breaks a bank-state rule or a minimum spacing rule raises a violation flag. The flag holds until software-independent logic pulses a synchronous clear.

Each bank has a two-state machine. BANK_IDLE moves to BANK_OPEN on an activate aimed at that bank. BANK_OPEN moves back to BANK_IDLE on a precharge to that bank, on a precharge-all, or on a read or write with auto-precharge aimed at it. Every other command leaves the state alone. Each bank also owns down-counters for activate-to-column, row cycle, row precharge and write recovery. Shared counters cover activate-to-activate, the auto-precharge burst lockout, the mode-register settle time and the refresh cycle. All limits are parameters in clock cycles. A counter loaded with limit T at the issuing edge allows a dependent command T or more cycles later.

All outputs are registered. A command sampled at edge n shows its decoded code, its effect on the bank vector and any violation right after edge n.

Top module: `ddr_cmd_monitor`

## Requirements
- R1: The command code output is registered. With chip select high the code is 8 (deselect), whatever the strobes are. With chip select low, {RAS,CAS,WE} gives the code: 000 mode set = 1, 001 refresh = 2, 011 activate = 3, 101 read = 4, 100 write = 5, 010 precharge = 6, 110 burst stop = 7, 111 no-op = 0. After reset the code is 8, the bank vector is 0, the flag is low and the error code is 0.
- R2: The bank number is {BA0,BA1}. BA0 low and BA1 low select bank A (vector bit 0). BA1 high alone selects bank B (bit 1). BA0 high alone selects bank C (bit 2). Both high select bank D (bit 3).
- R3: Activate sets the bank's vector bit. Precharge with A10 low clears the selected bank's bit. Precharge with A10 high clears all four bits and ignores the bank bits.
- R4: Mode set while any bank is open gives error code 1. Refresh while any bank is open gives error code 2.
- R5: Read or write to a closed bank gives error code 3. Activate to an open bank gives error code 4.
- R6: Any command other than no-op or deselect gives error code 5 if it comes fewer than T_MRD cycles after a mode set. It gives error code 6 if it comes fewer than T_RFC cycles after a refresh.
- R7: Read or write with A10 high closes its bank. Any read or write fewer than BURST_CYC cycles later gives error code 7. An activate to that bank gives error code 11 if it comes earlier than BURST_CYC+T_RP cycles after the read, or earlier than BURST_CYC+T_WR+T_RP cycles after the write.
- R8: Read or write fewer than T_RCD cycles after an activate to the same bank gives error code 8.
- R9: Activate fewer than T_RRD cycles after any activate gives error code 9. Activate fewer than T_RC cycles after an activate to the same bank gives error code 10.
- R10: A precharge that closes an open bank starts T_RP. An activate to that bank fewer than T_RP cycles later gives error code 11.
- R11: A write without auto-precharge starts a window of BURST_CYC+T_WR cycles. A precharge that targets that bank while it is open inside that window gives error code 12. This applies to a single-bank precharge and to a precharge-all.
- R12: When several errors apply in one cycle, the lowest code is reported. The flag and the code of the first violation stay fixed until the clear input is high at an edge. At that edge they take the current cycle's result, which is 0 and low if the command is clean. With the flag low the code is 0. A violating command still updates the bank vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge samples |
| rst_n | input | 1 | Synchronous active-low reset |
| clr_i | input | 1 | Synchronous clear of the violation flag and code |
| cs_n_i | input | 1 | Chip select, low active |
| ras_n_i | input | 1 | Row strobe, low active |
| cas_n_i | input | 1 | Column strobe, low active |
| we_n_i | input | 1 | Write enable, low active |
| ba0_i | input | 1 | Bank select bit 0 |
| ba1_i | input | 1 | Bank select bit 1 |
| a10_i | input | 1 | Address bit 10: auto-precharge or precharge-all |
| cmd_o | output | 4 | Registered decoded command code |
| bank_open_o | output | 4 | Open bank vector, bit 0 = bank A |
| viol_o | output | 1 | Sticky violation flag |
| err_code_o | output | 4 | Code of the first violation since the last clear |

## Verification
The bench drives directed command sequences and compares every output every cycle against a behavioural model. The model tracks an earliest-legal-cycle number per rule.

- Clean sequences that meet a spacing exactly show that the counters do not fire one cycle early.
- Sequences one cycle short of a limit show that each limit is enforced and reported with its own code.
- Sequences that break a state rule and a spacing rule together separate the priority order.
- Precharge-all with non-zero bank bits shows that the bank bits are ignored.
- Back-to-back violations without a clear show that the first code is retained.
- Auto-precharge reads and writes show that the read and write recovery windows differ.

// File: rtl/ddr_mon_pkg.sv
package ddr_mon_pkg;

    typedef enum logic [3:0] {
        CMD_NOP   = 4'd0,
        CMD_MRS   = 4'd1,
        CMD_REF   = 4'd2,
        CMD_ACT   = 4'd3,
        CMD_RD    = 4'd4,
        CMD_WR    = 4'd5,
        CMD_PRE   = 4'd6,
        CMD_BST   = 4'd7,
        CMD_DESEL = 4'd8
    } cmd_e;

    typedef enum logic {
        BANK_IDLE = 1'b0,
        BANK_OPEN = 1'b1
    } bank_st_e;

    localparam logic [3:0] ERR_NONE      = 4'd0;
    localparam logic [3:0] ERR_MRS_OPEN  = 4'd1;
    localparam logic [3:0] ERR_REF_OPEN  = 4'd2;
    localparam logic [3:0] ERR_RW_CLOSED = 4'd3;
    localparam logic [3:0] ERR_ACT_OPEN  = 4'd4;
    localparam logic [3:0] ERR_MRD       = 4'd5;
    localparam logic [3:0] ERR_RFC       = 4'd6;
    localparam logic [3:0] ERR_AP_LOCK   = 4'd7;
    localparam logic [3:0] ERR_RCD       = 4'd8;
    localparam logic [3:0] ERR_RRD       = 4'd9;
    localparam logic [3:0] ERR_RC        = 4'd10;
    localparam logic [3:0] ERR_RP        = 4'd11;
    localparam logic [3:0] ERR_WR        = 4'd12;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ddr_gap_timer.sv
module ddr_gap_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] value,
    output logic             busy
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= value;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign busy = (cnt_q != '0);

endmodule

// File: rtl/ddr_cmd_decode.sv
module ddr_cmd_decode
    import ddr_mon_pkg::*;
#(
    parameter int BA_W = 2
) (
    input  logic            cs_n,
    input  logic            ras_n,
    input  logic            cas_n,
    input  logic            we_n,
    input  logic            ba0,
    input  logic            ba1,
    output cmd_e            cmd,
    output logic [BA_W-1:0] bank
);

    always_comb begin
        if (cs_n) begin
            cmd = CMD_DESEL;
        end else begin
            unique case ({ras_n, cas_n, we_n})
                3'b000:  cmd = CMD_MRS;
                3'b001:  cmd = CMD_REF;
                3'b011:  cmd = CMD_ACT;
                3'b101:  cmd = CMD_RD;
                3'b100:  cmd = CMD_WR;
                3'b010:  cmd = CMD_PRE;
                3'b110:  cmd = CMD_BST;
                default: cmd = CMD_NOP;
            endcase
        end
    end

    // BA0 carries the weight-2 bit of the bank number
    assign bank = BA_W'({ba0, ba1});

endmodule

// File: rtl/ddr_bank_track.sv
module ddr_bank_track
    import ddr_mon_pkg::*;
#(
    parameter int CNT_W     = 4,
    parameter int T_RCD     = 3,
    parameter int T_RP      = 3,
    parameter int T_RC      = 9,
    parameter int T_WR      = 2,
    parameter int BURST_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  cmd_e cmd,
    input  logic hit,
    input  logic a10,
    output logic is_open,
    output logic rcd_busy,
    output logic rc_busy,
    output logic rp_busy,
    output logic wr_busy
);

    localparam logic [CNT_W-1:0] LD_RCD   = CNT_W'(T_RCD - 1);
    localparam logic [CNT_W-1:0] LD_RC    = CNT_W'(T_RC - 1);
    localparam logic [CNT_W-1:0] LD_RP    = CNT_W'(T_RP - 1);
    localparam logic [CNT_W-1:0] LD_AP_RD = CNT_W'(BURST_CYC + T_RP - 1);
    localparam logic [CNT_W-1:0] LD_AP_WR = CNT_W'(BURST_CYC + T_WR + T_RP - 1);
    localparam logic [CNT_W-1:0] LD_WR    = CNT_W'(BURST_CYC + T_WR - 1);

    bank_st_e st_q, st_nx;

    logic act_hit, pre_sel, ap_hit, close_ev;
    logic rp_load, wr_load;
    logic [CNT_W-1:0] rp_val;

    assign act_hit  = (cmd == CMD_ACT) && hit;
    assign pre_sel  = (cmd == CMD_PRE) && (hit || a10);
    assign ap_hit   = ((cmd == CMD_RD) || (cmd == CMD_WR)) && hit && a10;
    assign close_ev = pre_sel || ap_hit;

    // next-state logic
    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            BANK_IDLE: if (act_hit)  st_nx = BANK_OPEN;
            BANK_OPEN: if (close_ev) st_nx = BANK_IDLE;
            default:   st_nx = BANK_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= BANK_IDLE;
        else        st_q <= st_nx;
    end

    // outputs
    always_comb begin
        is_open = (st_q == BANK_OPEN);
    end

    always_comb begin
        rp_load = ap_hit || (pre_sel && (st_q == BANK_OPEN));
        if (ap_hit) rp_val = (cmd == CMD_WR) ? LD_AP_WR : LD_AP_RD;
        else        rp_val = LD_RP;
        wr_load = (cmd == CMD_WR) && hit && !a10;
    end

    ddr_gap_timer #(.CNT_W(CNT_W)) u_rcd (
        .clk(clk), .rst_n(rst_n), .load(act_hit), .value(LD_RCD), .busy(rcd_busy));

    ddr_gap_timer #(.CNT_W(CNT_W)) u_rc (
        .clk(clk), .rst_n(rst_n), .load(act_hit), .value(LD_RC), .busy(rc_busy));

    ddr_gap_timer #(.CNT_W(CNT_W)) u_rp (
        .clk(clk), .rst_n(rst_n), .load(rp_load), .value(rp_val), .busy(rp_busy));

    ddr_gap_timer #(.CNT_W(CNT_W)) u_wr (
        .clk(clk), .rst_n(rst_n), .load(wr_load), .value(LD_WR), .busy(wr_busy));

endmodule

// File: rtl/ddr_rule_check.sv
module ddr_rule_check
    import ddr_mon_pkg::*;
#(
    parameter int BA_W      = 2,
    parameter int CNT_W     = 4,
    parameter int T_RRD     = 2,
    parameter int T_RFC     = 10,
    parameter int T_MRD     = 2,
    parameter int BURST_CYC = 4,
    localparam int NBANK    = 1 << BA_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  cmd_e             cmd,
    input  logic [BA_W-1:0]  bank,
    input  logic             a10,
    input  logic [NBANK-1:0] open_v,
    input  logic [NBANK-1:0] rcd_v,
    input  logic [NBANK-1:0] rc_v,
    input  logic [NBANK-1:0] rp_v,
    input  logic [NBANK-1:0] wr_v,
    output cmd_e             cmd_q,
    output logic             viol_q,
    output logic [3:0]       err_q
);

    localparam logic [CNT_W-1:0] LD_RRD = CNT_W'(T_RRD - 1);
    localparam logic [CNT_W-1:0] LD_RFC = CNT_W'(T_RFC - 1);
    localparam logic [CNT_W-1:0] LD_MRD = CNT_W'(T_MRD - 1);
    localparam logic [CNT_W-1:0] LD_AP  = CNT_W'(BURST_CYC - 1);

    logic rrd_busy, rfc_busy, mrd_busy, ap_busy;
    logic is_rw, is_idle, any_open, twr_hit;
    logic [NBANK-1:0] pre_tgt;
    logic [3:0] err_nx;

    assign is_rw    = (cmd == CMD_RD) || (cmd == CMD_WR);
    assign is_idle  = (cmd == CMD_NOP) || (cmd == CMD_DESEL);
    assign any_open = |open_v;

    always_comb begin
        pre_tgt = '0;
        if (a10) pre_tgt = '1;
        else     pre_tgt[bank] = 1'b1;
        twr_hit = (cmd == CMD_PRE) && |(pre_tgt & open_v & wr_v);
    end

    // lowest code first
    always_comb begin
        err_nx = ERR_NONE;
        if ((cmd == CMD_MRS) && any_open)                 err_nx = ERR_MRS_OPEN;
        else if ((cmd == CMD_REF) && any_open)            err_nx = ERR_REF_OPEN;
        else if (is_rw && !open_v[bank])                  err_nx = ERR_RW_CLOSED;
        else if ((cmd == CMD_ACT) && open_v[bank])        err_nx = ERR_ACT_OPEN;
        else if (!is_idle && mrd_busy)                    err_nx = ERR_MRD;
        else if (!is_idle && rfc_busy)                    err_nx = ERR_RFC;
        else if (is_rw && ap_busy)                        err_nx = ERR_AP_LOCK;
        else if (is_rw && rcd_v[bank])                    err_nx = ERR_RCD;
        else if ((cmd == CMD_ACT) && rrd_busy)            err_nx = ERR_RRD;
        else if ((cmd == CMD_ACT) && rc_v[bank])          err_nx = ERR_RC;
        else if ((cmd == CMD_ACT) && rp_v[bank])          err_nx = ERR_RP;
        else if (twr_hit)                                 err_nx = ERR_WR;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q  <= CMD_DESEL;
            viol_q <= 1'b0;
            err_q  <= ERR_NONE;
        end else begin
            cmd_q <= cmd;
            if (clr) begin
                viol_q <= (err_nx != ERR_NONE);
                err_q  <= err_nx;
            end else if (!viol_q && (err_nx != ERR_NONE)) begin
                viol_q <= 1'b1;
                err_q  <= err_nx;
            end
        end
    end

    ddr_gap_timer #(.CNT_W(CNT_W)) u_rrd (
        .clk(clk), .rst_n(rst_n), .load(cmd == CMD_ACT), .value(LD_RRD), .busy(rrd_busy));

    ddr_gap_timer #(.CNT_W(CNT_W)) u_rfc (
        .clk(clk), .rst_n(rst_n), .load(cmd == CMD_REF), .value(LD_RFC), .busy(rfc_busy));

    ddr_gap_timer #(.CNT_W(CNT_W)) u_mrd (
        .clk(clk), .rst_n(rst_n), .load(cmd == CMD_MRS), .value(LD_MRD), .busy(mrd_busy));

    ddr_gap_timer #(.CNT_W(CNT_W)) u_ap (
        .clk(clk), .rst_n(rst_n), .load(is_rw && a10), .value(LD_AP), .busy(ap_busy));

endmodule

// File: rtl/ddr_cmd_monitor.sv
module ddr_cmd_monitor
    import ddr_mon_pkg::*;
#(
    parameter int BA_W      = 2,
    parameter int T_RCD     = 3,
    parameter int T_RP      = 3,
    parameter int T_RRD     = 2,
    parameter int T_RC      = 9,
    parameter int T_RFC     = 10,
    parameter int T_WR      = 2,
    parameter int T_MRD     = 2,
    parameter int BURST_CYC = 4,
    localparam int NBANK    = 1 << BA_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             cs_n_i,
    input  logic             ras_n_i,
    input  logic             cas_n_i,
    input  logic             we_n_i,
    input  logic             ba0_i,
    input  logic             ba1_i,
    input  logic             a10_i,
    output logic [3:0]       cmd_o,
    output logic [NBANK-1:0] bank_open_o,
    output logic             viol_o,
    output logic [3:0]       err_code_o
);

    localparam int MAX_LD = imax(imax(imax(T_RC, T_RFC), imax(T_RCD, T_RRD)),
                                 imax(imax(BURST_CYC + T_WR + T_RP, T_MRD), 2));
    localparam int CNT_W  = $clog2(MAX_LD + 1);

    cmd_e            cmd;
    cmd_e            cmd_q;
    logic [BA_W-1:0] bank;
    logic [NBANK-1:0] open_v, rcd_v, rc_v, rp_v, wr_v;

    ddr_cmd_decode #(.BA_W(BA_W)) u_dec (
        .cs_n  (cs_n_i),
        .ras_n (ras_n_i),
        .cas_n (cas_n_i),
        .we_n  (we_n_i),
        .ba0   (ba0_i),
        .ba1   (ba1_i),
        .cmd   (cmd),
        .bank  (bank)
    );

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        ddr_bank_track #(
            .CNT_W     (CNT_W),
            .T_RCD     (T_RCD),
            .T_RP      (T_RP),
            .T_RC      (T_RC),
            .T_WR      (T_WR),
            .BURST_CYC (BURST_CYC)
        ) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .cmd      (cmd),
            .hit      (bank == BA_W'(g)),
            .a10      (a10_i),
            .is_open  (open_v[g]),
            .rcd_busy (rcd_v[g]),
            .rc_busy  (rc_v[g]),
            .rp_busy  (rp_v[g]),
            .wr_busy  (wr_v[g])
        );
    end

    ddr_rule_check #(
        .BA_W      (BA_W),
        .CNT_W     (CNT_W),
        .T_RRD     (T_RRD),
        .T_RFC     (T_RFC),
        .T_MRD     (T_MRD),
        .BURST_CYC (BURST_CYC)
    ) u_rules (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr_i),
        .cmd    (cmd),
        .bank   (bank),
        .a10    (a10_i),
        .open_v (open_v),
        .rcd_v  (rcd_v),
        .rc_v   (rc_v),
        .rp_v   (rp_v),
        .wr_v   (wr_v),
        .cmd_q  (cmd_q),
        .viol_q (viol_o),
        .err_q  (err_code_o)
    );

    assign cmd_o       = cmd_q;
    assign bank_open_o = open_v;

endmodule

// File: rtl/ddr_cmd_monitor_chk.sv
module ddr_cmd_monitor_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       clr_i,
    input logic       cs_n_i,
    input logic       ras_n_i,
    input logic       cas_n_i,
    input logic       we_n_i,
    input logic       ba0_i,
    input logic       ba1_i,
    input logic       a10_i,
    input logic [3:0] cmd_o,
    input logic [3:0] bank_open_o,
    input logic       viol_o,
    input logic [3:0] err_code_o
);

    logic [1:0] idx;
    logic is_mrs, is_act, is_pre, is_rw;

    assign idx    = {ba0_i, ba1_i};
    assign is_mrs = !cs_n_i && !ras_n_i && !cas_n_i && !we_n_i;
    assign is_act = !cs_n_i && !ras_n_i &&  cas_n_i &&  we_n_i;
    assign is_pre = !cs_n_i && !ras_n_i &&  cas_n_i && !we_n_i;
    assign is_rw  = !cs_n_i &&  ras_n_i && !cas_n_i;

    assert_desel_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_i |=> (cmd_o == 4'd8));

    assert_act_opens_R3: assert property (@(posedge clk) disable iff (!rst_n)
        is_act |=> bank_open_o[$past(idx)]);

    assert_prea_closes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (is_pre && a10_i) |=> (bank_open_o == 4'b0000));

    assert_mrs_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (is_mrs && (bank_open_o != 4'b0000)) |=> viol_o);

    assert_rw_closed_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (is_rw && !bank_open_o[idx]) |=> viol_o);

    assert_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (viol_o && !clr_i) |=> (viol_o && $stable(err_code_o)));

    assert_code_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !viol_o |-> (err_code_o == 4'd0));

endmodule

bind ddr_cmd_monitor ddr_cmd_monitor_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr_i       (clr_i),
    .cs_n_i      (cs_n_i),
    .ras_n_i     (ras_n_i),
    .cas_n_i     (cas_n_i),
    .we_n_i      (we_n_i),
    .ba0_i       (ba0_i),
    .ba1_i       (ba1_i),
    .a10_i       (a10_i),
    .cmd_o       (cmd_o),
    .bank_open_o (bank_open_o),
    .viol_o      (viol_o),
    .err_code_o  (err_code_o)
);

// File: tb/tb_ddr_cmd_monitor.sv
module tb_ddr_cmd_monitor;

    localparam int T_RCD = 3, T_RP = 3, T_RRD = 2, T_RC = 9;
    localparam int T_RFC = 10, T_WR = 2, T_MRD = 2, BURST = 4;

    localparam logic [3:0] P_MRS = 4'b0000, P_REF = 4'b0001, P_ACT = 4'b0011;
    localparam logic [3:0] P_RD  = 4'b0101, P_WR  = 4'b0100, P_PRE = 4'b0010;
    localparam logic [3:0] P_BST = 4'b0110, P_NOP = 4'b0111, P_DES = 4'b1000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr_i = 1'b0;
    logic cs_n_i = 1'b1, ras_n_i = 1'b1, cas_n_i = 1'b1, we_n_i = 1'b1;
    logic ba0_i = 1'b0, ba1_i = 1'b0, a10_i = 1'b0;
    logic [3:0] cmd_o, bank_open_o, err_code_o;
    logic viol_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int tcyc = 0;
    bit open_m [4];
    int rcd_ok [4], rc_ok [4], rp_ok [4], wr_ok [4];
    int rrd_ok = 0, ap_ok = 0, mrd_ok = 0, rfc_ok = 0;
    int e_cmd = 8, e_viol = 0, e_err = 0;

    always #4 clk = ~clk;

    ddr_cmd_monitor #(
        .T_RCD(T_RCD), .T_RP(T_RP), .T_RRD(T_RRD), .T_RC(T_RC),
        .T_RFC(T_RFC), .T_WR(T_WR), .T_MRD(T_MRD), .BURST_CYC(BURST)
    ) dut (
        .clk(clk), .rst_n(rst_n), .clr_i(clr_i),
        .cs_n_i(cs_n_i), .ras_n_i(ras_n_i), .cas_n_i(cas_n_i), .we_n_i(we_n_i),
        .ba0_i(ba0_i), .ba1_i(ba1_i), .a10_i(a10_i),
        .cmd_o(cmd_o), .bank_open_o(bank_open_o),
        .viol_o(viol_o), .err_code_o(err_code_o)
    );

    function automatic logic [3:0] open_vec();
        logic [3:0] v;
        for (int i = 0; i < 4; i++) v[i] = open_m[i];
        return v;
    endfunction

    task automatic compare(input string tag);
        logic [3:0] eo;
        eo = open_vec();
        checks++;
        if (cmd_o !== 4'(e_cmd) || bank_open_o !== eo ||
            viol_o !== 1'(e_viol) || err_code_o !== 4'(e_err)) begin
            errors++;
            $display("FAIL %s t=%0d cmd=%0d/%0d open=%b/%b viol=%0d/%0d err=%0d/%0d",
                     tag, tcyc, cmd_o, e_cmd, bank_open_o, eo,
                     viol_o, e_viol, err_code_o, e_err);
        end
    endtask

    task automatic expect_err(input int code, input string tag);
        checks++;
        if (viol_o !== 1'b1 || err_code_o !== 4'(code)) begin
            errors++;
            $display("FAIL %s viol=%0d err=%0d expected viol=1 err=%0d",
                     tag, viol_o, err_code_o, code);
        end
    endtask

    task automatic expect_clean(input string tag);
        checks++;
        if (viol_o !== 1'b0) begin
            errors++;
            $display("FAIL %s viol=%0d err=%0d expected viol=0", tag, viol_o, err_code_o);
        end
    endtask

    task automatic issue(input logic [3:0] p, input int b, input logic a,
                         input logic c, input string tag);
        int code, e;
        bit anyo, rw, idle, twr;
        if (p[3]) code = 8;
        else case (p[2:0])
            3'b000: code = 1;  3'b001: code = 2;  3'b011: code = 3;
            3'b101: code = 4;  3'b100: code = 5;  3'b010: code = 6;
            3'b110: code = 7;  default: code = 0;
        endcase
        anyo = (open_vec() != 4'b0);
        rw   = (code == 4) || (code == 5);
        idle = (code == 0) || (code == 8);
        twr  = 0;
        if (code == 6)
            for (int i = 0; i < 4; i++)
                if ((a || i == b) && open_m[i] && tcyc < wr_ok[i]) twr = 1;
        e = 0;
        if (code == 1 && anyo)                   e = 1;
        else if (code == 2 && anyo)              e = 2;
        else if (rw && !open_m[b])               e = 3;
        else if (code == 3 && open_m[b])         e = 4;
        else if (!idle && tcyc < mrd_ok)         e = 5;
        else if (!idle && tcyc < rfc_ok)         e = 6;
        else if (rw && tcyc < ap_ok)             e = 7;
        else if (rw && tcyc < rcd_ok[b])         e = 8;
        else if (code == 3 && tcyc < rrd_ok)     e = 9;
        else if (code == 3 && tcyc < rc_ok[b])   e = 10;
        else if (code == 3 && tcyc < rp_ok[b])   e = 11;
        else if (twr)                            e = 12;
        e_cmd = code;
        if (c) begin
            e_viol = (e != 0); e_err = e;
        end else if (e_viol == 0 && e != 0) begin
            e_viol = 1; e_err = e;
        end
        case (code)
            1: mrd_ok = tcyc + T_MRD;
            2: rfc_ok = tcyc + T_RFC;
            3: begin
                open_m[b] = 1; rcd_ok[b] = tcyc + T_RCD;
                rc_ok[b] = tcyc + T_RC; rrd_ok = tcyc + T_RRD;
            end
            4, 5: begin
                if (a) begin
                    ap_ok = tcyc + BURST; open_m[b] = 0;
                    rp_ok[b] = tcyc + BURST + T_RP + ((code == 5) ? T_WR : 0);
                end else if (code == 5) begin
                    wr_ok[b] = tcyc + BURST + T_WR;
                end
            end
            6: for (int i = 0; i < 4; i++)
                if ((a || i == b) && open_m[i]) begin
                    open_m[i] = 0; rp_ok[i] = tcyc + T_RP;
                end
            default: ;
        endcase
        {cs_n_i, ras_n_i, cas_n_i, we_n_i} = p;
        ba0_i = b[1]; ba1_i = b[0]; a10_i = a; clr_i = c;
        @(posedge clk);
        @(negedge clk);
        compare(tag);
        tcyc++;
    endtask

    task automatic nops(input int n, input string tag);
        for (int i = 0; i < n; i++) issue(P_NOP, 0, 1'b0, 1'b0, tag);
    endtask

    task automatic clear(input string tag);
        issue(P_NOP, 0, 1'b0, 1'b1, tag);
    endtask

    task automatic settle(input string tag);
        nops(12, tag);
        issue(P_PRE, 0, 1'b1, 1'b0, tag);
        nops(4, tag);
    endtask

    initial begin
        for (int i = 0; i < 4; i++) begin
            open_m[i] = 0; rcd_ok[i] = 0; rc_ok[i] = 0; rp_ok[i] = 0; wr_ok[i] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        compare("R1 reset state");

        // R1: deselect masks strobes, codes of plain commands
        issue(4'b1000, 0, 1'b0, 1'b0, "R1 deselect with strobes low");
        checks++;
        if (cmd_o !== 4'd8) begin
            errors++; $display("FAIL R1 cmd=%0d expected 8", cmd_o);
        end
        issue(P_NOP, 0, 1'b0, 1'b0, "R1 nop");
        issue(P_BST, 0, 1'b0, 1'b0, "R1 burst stop");
        issue(P_DES, 0, 1'b0, 1'b0, "R1 deselect");
        expect_clean("R1 no violation");

        // R6: mode set then activate too early
        issue(P_MRS, 0, 1'b0, 1'b0, "R6 mrs idle");
        issue(P_ACT, 0, 1'b0, 1'b0, "R6 act after mrs");
        expect_err(5, "R6 mrd");
        clear("R6 clear");
        settle("R6 settle");

        // R6: refresh then activate too early
        issue(P_REF, 0, 1'b0, 1'b0, "R6 ref idle");
        issue(P_NOP, 0, 1'b0, 1'b0, "R6 nop");
        issue(P_ACT, 1, 1'b0, 1'b0, "R6 act after ref");
        expect_err(6, "R6 rfc");
        clear("R6 clear");
        settle("R6 settle");

        // R4: mode set / refresh with a bank open
        issue(P_ACT, 0, 1'b0, 1'b0, "R4 act A");
        nops(4, "R4 nop");
        issue(P_MRS, 0, 1'b0, 1'b0, "R4 mrs open");
        expect_err(1, "R4 mrs open");
        clear("R4 clear");
        issue(P_REF, 0, 1'b0, 1'b0, "R4 ref open");
        expect_err(2, "R4 ref open");
        clear("R4 clear");
        settle("R4 settle");

        // R5 and R2: read closed bank, activate open bank
        issue(P_RD, 1, 1'b0, 1'b0, "R5 read closed B");
        expect_err(3, "R5 rw closed");
        clear("R5 clear");
        issue(P_ACT, 2, 1'b0, 1'b0, "R2 act C");
        checks++;
        if (bank_open_o !== 4'b0100) begin
            errors++; $display("FAIL R2 open=%b expected 0100", bank_open_o);
        end
        nops(3, "R5 nop");
        issue(P_ACT, 2, 1'b0, 1'b0, "R5 act open C");
        expect_err(4, "R5 act open");
        clear("R5 clear");
        settle("R5 settle");

        // R8: activate to column spacing, exact and short
        issue(P_ACT, 3, 1'b0, 1'b0, "R8 act D");
        nops(2, "R8 nop");
        issue(P_RD, 3, 1'b0, 1'b0, "R8 read at limit");
        expect_clean("R8 exact tRCD");
        settle("R8 settle");
        issue(P_ACT, 2, 1'b0, 1'b0, "R8 act C");
        issue(P_WR, 2, 1'b0, 1'b0, "R8 write early");
        expect_err(8, "R8 rcd");
        clear("R8 clear");
        settle("R8 settle");

        // R9: activate-activate and row cycle
        issue(P_ACT, 0, 1'b0, 1'b0, "R9 act A");
        issue(P_ACT, 1, 1'b0, 1'b0, "R9 act B early");
        expect_err(9, "R9 rrd");
        clear("R9 clear");
        settle("R9 settle");
        issue(P_ACT, 0, 1'b0, 1'b0, "R9 act A");
        nops(2, "R9 nop");
        issue(P_PRE, 0, 1'b0, 1'b0, "R9 pre A");
        nops(2, "R9 nop");
        issue(P_ACT, 0, 1'b0, 1'b0, "R9 act A inside tRC");
        expect_err(10, "R9 rc");
        clear("R9 clear");
        settle("R9 settle");

        // R10: precharge to activate; R3 precharge-all ignores bank bits
        issue(P_ACT, 0, 1'b0, 1'b0, "R10 act A");
        nops(8, "R10 nop");
        issue(P_PRE, 0, 1'b0, 1'b0, "R10 pre A");
        issue(P_ACT, 0, 1'b0, 1'b0, "R10 act A early");
        expect_err(11, "R10 rp");
        clear("R10 clear");
        nops(12, "R3 nop");
        issue(P_ACT, 2, 1'b0, 1'b0, "R3 act C");
        nops(2, "R3 nop");
        issue(P_PRE, 1, 1'b0, 1'b0, "R3 pre B single");
        checks++;
        if (bank_open_o !== 4'b0101) begin
            errors++; $display("FAIL R3 open=%b expected 0101", bank_open_o);
        end
        issue(P_PRE, 1, 1'b1, 1'b0, "R3 pre all with bank B bits");
        checks++;
        if (bank_open_o !== 4'b0000) begin
            errors++; $display("FAIL R3 open=%b expected 0000", bank_open_o);
        end
        settle("R3 settle");

        // R7: auto-precharge lockout and read recovery
        issue(P_ACT, 0, 1'b0, 1'b0, "R7 act A");
        issue(P_NOP, 0, 1'b0, 1'b0, "R7 nop");
        issue(P_ACT, 3, 1'b0, 1'b0, "R7 act D");
        nops(2, "R7 nop");
        issue(P_RD, 3, 1'b1, 1'b0, "R7 read D auto");
        expect_clean("R7 legal auto read");
        issue(P_RD, 0, 1'b0, 1'b0, "R7 read A in lockout");
        expect_err(7, "R7 ap lock");
        clear("R7 clear");
        nops(3, "R7 nop");
        issue(P_ACT, 3, 1'b0, 1'b0, "R7 act D before burst+tRP");
        expect_err(11, "R7 ap read recovery");
        clear("R7 clear");
        settle("R7 settle");

        // R7: auto-precharge write adds write recovery
        issue(P_ACT, 1, 1'b0, 1'b0, "R7 act B");
        nops(2, "R7 nop");
        issue(P_WR, 1, 1'b1, 1'b0, "R7 write B auto");
        nops(7, "R7 nop");
        issue(P_ACT, 1, 1'b0, 1'b0, "R7 act B one short");
        expect_err(11, "R7 ap write recovery");
        clear("R7 clear");
        settle("R7 settle");

        // R11: write recovery, single and precharge-all
        issue(P_ACT, 0, 1'b0, 1'b0, "R11 act A");
        nops(2, "R11 nop");
        issue(P_WR, 0, 1'b0, 1'b0, "R11 write A");
        nops(4, "R11 nop");
        issue(P_PRE, 0, 1'b0, 1'b0, "R11 pre A early");
        expect_err(12, "R11 wr");
        clear("R11 clear");
        settle("R11 settle");
        issue(P_ACT, 2, 1'b0, 1'b0, "R11 act C");
        nops(2, "R11 nop");
        issue(P_WR, 2, 1'b0, 1'b0, "R11 write C");
        nops(5, "R11 nop");
        issue(P_PRE, 0, 1'b1, 1'b0, "R11 pre all at limit");
        expect_clean("R11 exact tWR");
        settle("R11 settle");

        // R12: priority, retention, clear with concurrent violation
        issue(P_ACT, 0, 1'b0, 1'b0, "R12 act A");
        issue(P_ACT, 0, 1'b0, 1'b0, "R12 act A again");
        expect_err(4, "R12 priority open over rrd");
        issue(P_RD, 1, 1'b0, 1'b0, "R12 second violation");
        expect_err(4, "R12 first code kept");
        issue(P_RD, 2, 1'b0, 1'b1, "R12 clear with violation");
        expect_err(3, "R12 clear captures current");
        clear("R12 clear");
        expect_clean("R12 cleared");
        settle("R12 settle");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule